// File: doc/BRIEF.md
# Block Erase Sequencer with Suspend

This block is the internal sequencer that carries out a block erase in a flash-style memory controller. After the command decoder accepts an erase request, the sequencer works through the operation by itself. It first runs a preconditioning phase. It then alternates erase pulses with verify phases until the block reads blank or the pulse budget is used up. The phase lengths and the pulse budget are cycle counts set by parameters. Only one block is erased per operation. The block address is captured when the operation starts and is driven toward a behavioural array model for as long as the erase runs. The array model reports through `blank_i` whether the block is fully erased.

The sequencer keeps a status byte. Its error flags are sticky: only the clear-status request resets them. A host can therefore run a batch of erases and inspect the flags once at the end. If the programming-voltage flag is low when an erase is requested, the erase is refused and the refusal is recorded in the status byte. A suspend request takes effect only at the next phase boundary, so an erase pulse is never cut short. While suspended, the sequencer reports ready. A resume request continues the erase from the saved phase and pulse count.

Top module: `erase_seq`

## Requirements
- R1: After reset, `status_o` is 8'h80, `ry_by_o` is 1 (ready) and `erase_pulse_o` is 0.
- R2: A `start_i` accepted while idle with `vpp_ok_i`=1 makes `ry_by_o` low from the next cycle. The erase then runs PRE_CYC cycles of preconditioning, followed by pulse/verify rounds of PULSE_CYC + VFY_CYC cycles each. The busy time for n rounds is PRE_CYC + n*(PULSE_CYC+VFY_CYC) cycles.
- R3: If `blank_i` is 1 in the last verify cycle, the erase ends. `ry_by_o` returns to 1 and no new error bit is set.
- R4: If the block is still not blank after MAX_PULSES pulses, the erase ends as ready with bit 5 (erase error) set.
- R5: A start request while idle with `vpp_ok_i`=0 sets bit 3 (low programming voltage) and bit 5. No pulse is issued and `ry_by_o` stays 1.
- R6: Bits 5 and 3 stay set through later operations, including successful ones. Only `clr_status_i` clears them.
- R7: A suspend request while busy takes effect at the next phase boundary. Every erase pulse lasts exactly PULSE_CYC cycles. While suspended, bits 7 and 6 read 1, `ry_by_o` is 1, and no pulse is issued.
- R8: A resume request while suspended clears bit 6 and makes the sequencer busy again from the next cycle. The remaining work is completed, so the total busy time and pulse count equal those of an unsuspended erase.
- R9: A resume request while not suspended has no effect. A start request while busy or suspended has no effect.
- R10: Status layout: bit 7 is ready, bit 6 is suspended, bit 5 is erase error, bit 4 is write error (never set by this erase-only sequencer), bit 3 is low voltage, and bits 2..0 read 0.
- R11: `erase_blk_o` holds the block address captured at the accepted start for the whole erase, even if `blk_addr_i` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Erase request from the command decoder |
| suspend_i | input | 1 | Suspend request |
| resume_i | input | 1 | Resume request |
| clr_status_i | input | 1 | Clear the sticky error bits |
| blk_addr_i | input | BLK_W | Block to erase, sampled at start |
| vpp_ok_i | input | 1 | Programming voltage valid |
| blank_i | input | 1 | Array model reports the block fully erased |
| status_o | output | 8 | Status byte |
| ry_by_o | output | 1 | 1 = ready, 0 = busy |
| erase_pulse_o | output | 1 | Erase strobe toward the array model |
| erase_blk_o | output | BLK_W | Block being erased |

## Verification
The assertions assume that each request is a single-cycle pulse. They also assume that start and resume are not raised in the same cycle, and that `blank_i` comes from an array model that only turns blank after erase pulses. The bench drives each request for exactly one cycle, between clock edges, and never combines start with resume. Its array model derives `blank_i` from the number of erase pulses it has seen, against a per-scenario target. This keeps the verify outcome consistent with the pulses that have actually been issued.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE, PH_PRECOND, PH_PULSE, PH_VERIFY, PH_SUSP
  } phase_e;

  localparam int SR_RDY  = 7;
  localparam int SR_SUSP = 6;
  localparam int SR_ERR  = 5;
  localparam int SR_WERR = 4;
  localparam int SR_VPP  = 3;
endpackage

// File: rtl/erase_phase_timer.sv
module erase_phase_timer
  import erase_seq_pkg::*;
#(
  parameter int PRE_CYC   = 5,
  parameter int PULSE_CYC = 8,
  parameter int VFY_CYC   = 3,
  parameter int CNT_W     = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  phase_e phase_i,
  output logic   done_o
);
  logic [CNT_W-1:0] cnt_q, lim;
  logic             run;

  always_comb begin
    run = 1'b1;
    case (phase_i)
      PH_PRECOND: lim = CNT_W'(PRE_CYC - 1);
      PH_PULSE:   lim = CNT_W'(PULSE_CYC - 1);
      PH_VERIFY:  lim = CNT_W'(VFY_CYC - 1);
      default: begin
        lim = '0;
        run = 1'b0;
      end
    endcase
  end

  assign done_o = run && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run || done_o)  cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/erase_status.sv
module erase_status
  import erase_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_err_i,
  input  logic       set_vpp_i,
  input  logic       clr_i,
  input  logic       ready_i,
  input  logic       susp_i,
  output logic [7:0] status_o
);
  logic err_q, vpp_q;

  // a new error in the same cycle as a clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q <= 1'b0;
      vpp_q <= 1'b0;
    end else begin
      if (set_err_i)  err_q <= 1'b1;
      else if (clr_i) err_q <= 1'b0;
      if (set_vpp_i)  vpp_q <= 1'b1;
      else if (clr_i) vpp_q <= 1'b0;
    end
  end

  always_comb begin
    status_o          = '0;
    status_o[SR_RDY]  = ready_i;
    status_o[SR_SUSP] = susp_i;
    status_o[SR_ERR]  = err_q;
    status_o[SR_WERR] = 1'b0;
    status_o[SR_VPP]  = vpp_q;
  end
endmodule

// File: rtl/erase_ctrl.sv
module erase_ctrl
  import erase_seq_pkg::*;
#(
  parameter int MAX_PULSES = 4,
  parameter int BLK_W      = 4,
  parameter int PC_W       = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             suspend_i,
  input  logic             resume_i,
  input  logic             vpp_ok_i,
  input  logic [BLK_W-1:0] blk_i,
  input  logic             blank_i,
  input  logic             done_i,
  output phase_e           phase_o,
  output logic             set_err_o,
  output logic             set_vpp_o,
  output logic [BLK_W-1:0] blk_o
);
  phase_e           phase_q, saved_q, tgt;
  logic             susp_req_q, at_max, active, refuse;
  logic [PC_W-1:0]  pulses_q;
  logic [BLK_W-1:0] blk_q;

  assign at_max = (pulses_q == PC_W'(MAX_PULSES));
  assign active = (phase_q == PH_PRECOND) || (phase_q == PH_PULSE) ||
                  (phase_q == PH_VERIFY);
  assign refuse = (phase_q == PH_IDLE) && start_i && !vpp_ok_i;

  // next phase once the current one completes
  always_comb begin
    case (phase_q)
      PH_PRECOND: tgt = PH_PULSE;
      PH_PULSE:   tgt = PH_VERIFY;
      PH_VERIFY:  tgt = (blank_i || at_max) ? PH_IDLE : PH_PULSE;
      default:    tgt = PH_IDLE;
    endcase
  end

  assign set_vpp_o = refuse;
  assign set_err_o = refuse ||
                     ((phase_q == PH_VERIFY) && done_i && !blank_i && at_max);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_IDLE;
      saved_q    <= PH_IDLE;
      susp_req_q <= 1'b0;
      pulses_q   <= '0;
      blk_q      <= '0;
    end else begin
      if (phase_q == PH_IDLE) begin
        if (start_i && vpp_ok_i) begin
          phase_q  <= PH_PRECOND;
          blk_q    <= blk_i;
          pulses_q <= '0;
        end
      end else if (phase_q == PH_SUSP) begin
        if (resume_i) phase_q <= saved_q;
      end else if (active) begin
        if (suspend_i) susp_req_q <= 1'b1;
        if (done_i) begin
          if (phase_q == PH_PULSE) pulses_q <= pulses_q + 1'b1;
          if (tgt == PH_IDLE) begin
            phase_q    <= PH_IDLE;
            susp_req_q <= 1'b0;
          end else if (susp_req_q || suspend_i) begin
            phase_q    <= PH_SUSP;
            saved_q    <= tgt;
            susp_req_q <= 1'b0;
          end else begin
            phase_q <= tgt;
          end
        end
      end
    end
  end

  assign phase_o = phase_q;
  assign blk_o   = blk_q;
endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int BLK_W      = 4,
  parameter int PRE_CYC    = 5,
  parameter int PULSE_CYC  = 8,
  parameter int VFY_CYC    = 3,
  parameter int MAX_PULSES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             suspend_i,
  input  logic             resume_i,
  input  logic             clr_status_i,
  input  logic [BLK_W-1:0] blk_addr_i,
  input  logic             vpp_ok_i,
  input  logic             blank_i,
  output logic [7:0]       status_o,
  output logic             ry_by_o,
  output logic             erase_pulse_o,
  output logic [BLK_W-1:0] erase_blk_o
);
  localparam int MAX_A   = (PRE_CYC > PULSE_CYC) ? PRE_CYC : PULSE_CYC;
  localparam int MAX_CYC = (MAX_A > VFY_CYC) ? MAX_A : VFY_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int PC_W    = $clog2(MAX_PULSES + 1);

  phase_e phase;
  logic   done, set_err, set_vpp, ready;

  erase_phase_timer #(
    .PRE_CYC(PRE_CYC), .PULSE_CYC(PULSE_CYC), .VFY_CYC(VFY_CYC), .CNT_W(CNT_W)
  ) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .phase_i(phase), .done_o(done)
  );

  erase_ctrl #(
    .MAX_PULSES(MAX_PULSES), .BLK_W(BLK_W), .PC_W(PC_W)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .suspend_i(suspend_i),
    .resume_i(resume_i), .vpp_ok_i(vpp_ok_i), .blk_i(blk_addr_i),
    .blank_i(blank_i), .done_i(done), .phase_o(phase), .set_err_o(set_err),
    .set_vpp_o(set_vpp), .blk_o(erase_blk_o)
  );

  assign ready = (phase == PH_IDLE) || (phase == PH_SUSP);

  erase_status u_status (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_err_i(set_err), .set_vpp_i(set_vpp),
    .clr_i(clr_status_i), .ready_i(ready), .susp_i(phase == PH_SUSP),
    .status_o(status_o)
  );

  assign ry_by_o       = ready;
  assign erase_pulse_o = (phase == PH_PULSE);
endmodule

// File: rtl/erase_seq_chk.sv
module erase_seq_chk #(
  parameter int BLK_W     = 4,
  parameter int PULSE_CYC = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             resume_i,
  input logic             clr_status_i,
  input logic             vpp_ok_i,
  input logic [7:0]       status_o,
  input logic             ry_by_o,
  input logic             erase_pulse_o,
  input logic [BLK_W-1:0] erase_blk_o
);
  logic [15:0] run_len;
  logic        prev_pulse;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_len    <= '0;
      prev_pulse <= 1'b0;
    end else begin
      run_len    <= erase_pulse_o ? run_len + 1'b1 : '0;
      prev_pulse <= erase_pulse_o;
    end
  end

  assert_pulse_len_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (prev_pulse && !erase_pulse_o) |-> (run_len == 16'(PULSE_CYC)));

  assert_pulse_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_pulse_o |-> !ry_by_o);

  assert_susp_ready_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[6] |-> (status_o[7] && ry_by_o && !erase_pulse_o));

  assert_sticky_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[5] && !clr_status_i) |=> status_o[5]);

  assert_sticky_vpp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[3] && !clr_status_i) |=> status_o[3]);

  assert_vpp_refuse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && status_o[7] && !status_o[6] && !vpp_ok_i)
      |=> (status_o[3] && status_o[5] && ry_by_o && !erase_pulse_o));

  assert_resume_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_i && !start_i && status_o[7] && !status_o[6]) |=> ry_by_o);

  assert_blk_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ry_by_o |=> (ry_by_o || $stable(erase_blk_o)));

  always @(posedge clk_i) begin
    if (rst_ni) begin
      assert_layout_R10: assert (status_o[4] == 1'b0 && status_o[2:0] == 3'b000);
    end
  end
endmodule

bind erase_seq erase_seq_chk #(.BLK_W(BLK_W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .resume_i(resume_i),
  .clr_status_i(clr_status_i), .vpp_ok_i(vpp_ok_i), .status_o(status_o),
  .ry_by_o(ry_by_o), .erase_pulse_o(erase_pulse_o), .erase_blk_o(erase_blk_o)
);

// File: tb/erase_seq_test.sv
`timescale 1ns/1ps
module erase_seq_test;
  localparam int BLK_W = 4, PRE = 5, PUL = 8, VFY = 3, MAXP = 4;
  localparam int ROUND = PUL + VFY;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, susp = 0, resume = 0, clr = 0, vpp = 1;
  logic [BLK_W-1:0] blk_addr = '0;
  logic blank;
  logic [7:0] status;
  logic ry, pulse;
  logic [BLK_W-1:0] eblk;

  int checks = 0, fails = 0;
  int busy_cnt = 0, edges = 0, run = 0, bad_len = 0, bad_blk = 0, need = 1;
  logic prev_p = 1'b0;
  logic [BLK_W-1:0] exp_blk = '0;

  always #2 clk = ~clk;

  erase_seq #(.BLK_W(BLK_W), .PRE_CYC(PRE), .PULSE_CYC(PUL), .VFY_CYC(VFY),
              .MAX_PULSES(MAXP)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .suspend_i(susp),
    .resume_i(resume), .clr_status_i(clr), .blk_addr_i(blk_addr),
    .vpp_ok_i(vpp), .blank_i(blank), .status_o(status), .ry_by_o(ry),
    .erase_pulse_o(pulse), .erase_blk_o(eblk)
  );

  // array model: blank after `need` pulses
  assign blank = (edges >= need);

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ry) busy_cnt++;
      if (pulse && !prev_p) edges++;
      if (pulse) begin
        run++;
        if (eblk !== exp_blk) bad_blk++;
      end else begin
        if (prev_p && run != PUL) bad_len++;
        run = 0;
      end
      prev_p = pulse;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon(input int n);
    busy_cnt = 0; edges = 0; bad_len = 0; bad_blk = 0; need = n;
  endtask

  task automatic do_start(input logic [BLK_W-1:0] b, input logic v);
    @(negedge clk);
    blk_addr = b; vpp = v; start = 1;
    @(negedge clk);
    start = 0; blk_addr = ~b; vpp = 1;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000 && !ry; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 status", status, 8'h80);
    chk("R1 ry_by", ry, 1);
    chk("R1 pulse", pulse, 0);
    chk("R10 reserved bits", status & 8'h17, 0);
  endtask

  task automatic t_erase_ok();
    clear_mon(2); exp_blk = 4'h5;
    do_start(4'h5, 1);
    chk("R2 busy after start", ry, 0);
    repeat (8) @(negedge clk);
    do_start(4'h9, 1); // ignored while busy
    wait_ready();
    chk("R2 busy cycles", busy_cnt, PRE + 2 * ROUND);
    chk("R2 pulse count", edges, 2);
    chk("R7 pulse length", bad_len, 0);
    chk("R11 block held", bad_blk, 0);
    chk("R3 status after success", status, 8'h80);
    chk("R9 start while busy ignored", ry, 1);
  endtask

  task automatic t_max_fail();
    clear_mon(1000); exp_blk = 4'h3;
    do_start(4'h3, 1);
    wait_ready();
    chk("R4 pulses used", edges, MAXP);
    chk("R4 busy cycles", busy_cnt, PRE + MAXP * ROUND);
    chk("R4 status", status, 8'hA0);
  endtask

  task automatic t_sticky_vpp();
    clear_mon(1); exp_blk = 4'hC;
    do_start(4'hC, 1);
    wait_ready();
    chk("R6 error kept after success", status, 8'hA0);
    chk("R6 success ran", busy_cnt, PRE + ROUND);
    clear_mon(1);
    do_start(4'h6, 0);
    chk("R5 stays ready", ry, 1);
    chk("R5 status", status, 8'hA8);
    repeat (5) @(negedge clk);
    chk("R5 no pulse", edges, 0);
    chk("R5 no busy", busy_cnt, 0);
    do_start(4'hA, 0); // second refusal keeps bits
    chk("R6 bits held", status, 8'hA8);
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
    chk("R6 cleared by clear request", status, 8'h80);
  endtask

  task automatic t_suspend();
    int e0;
    clear_mon(3); exp_blk = 4'h7;
    do_start(4'h7, 1);
    repeat (6) @(negedge clk);
    susp = 1;
    @(negedge clk) susp = 0;
    for (int i = 0; i < 100 && !status[6]; i++) @(negedge clk);
    chk("R7 suspended status", status, 8'hC0);
    chk("R7 ready while suspended", ry, 1);
    chk("R7 pulse length", bad_len, 0);
    e0 = edges;
    repeat (20) @(negedge clk);
    chk("R7 no pulse while suspended", edges, e0);
    chk("R7 pulse low", pulse, 0);
    do_start(4'h2, 1); // ignored while suspended
    chk("R9 start while suspended", status, 8'hC0);
    @(negedge clk) resume = 1;
    @(negedge clk) resume = 0;
    chk("R8 busy after resume", ry, 0);
    chk("R8 suspend bit cleared", status[6], 0);
    wait_ready();
    chk("R8 total busy", busy_cnt, PRE + 3 * ROUND);
    chk("R8 total pulses", edges, 3);
    chk("R8 final status", status, 8'h80);
    chk("R11 block held across suspend", bad_blk, 0);
  endtask

  task automatic t_resume_idle();
    clear_mon(1);
    @(negedge clk) resume = 1;
    @(negedge clk) resume = 0;
    repeat (5) @(negedge clk);
    chk("R9 resume idle ready", ry, 1);
    chk("R9 resume idle status", status, 8'h80);
    chk("R9 resume idle no pulse", edges, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_erase_ok();
    t_max_fail();
    t_sticky_vpp();
    t_suspend();
    t_resume_idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule